// File: doc/BRIEF.md
# Six-Operand Signed Carry-Save Adder

This block adds six signed two's-complement operands of equal width and returns their exact sum on one output wide enough that no combination of inputs can overflow. It is meant for places such as a small filter tap accumulator, where several products or samples arrive in parallel and must be added in one step. The slow carry ripple is paid only once, not after every pairwise addition.

Internally the six operands become six partial rows. A tree of full-adder cells reduces them in three carry-save levels, from six rows to four, then three, then two. One carry-propagate adder then turns the remaining sum and carry rows into the result. The block does not copy each operand's sign bit across the upper columns. It inverts each operand's top bit and adds one fixed bias word. That word is a multiple of two to the operand width, so it fits in the otherwise empty upper columns of the first row and costs no extra row. An input register stage and an output register stage can each be switched on by a parameter. Both are on by default, which gives a pipelined block with a fixed latency for clocked use.

Top module: `csa6_adder`

## Requirements
- R1: `sum_o` equals the exact signed sum of the six operands, with each operand sign-extended to W+3 bits. With the default W=6 the output is 9 bits wide.
- R2: The extreme inputs are summed without overflow. Six copies of the most negative value (-32 for W=6) give -192 (9'h140). Six copies of the most positive value (+31) give +186.
- R3: The first reduction level compresses the six rows with two independent 3:2 groups. The four rows it produces sum, modulo 2^(W+3), to the same value as the six operands.
- R4: The second and third levels reduce four rows to three, and then three rows to two. The row total is unchanged at each level.
- R5: The final carry-propagate adder returns exactly the modulo 2^(W+3) sum of the last sum row and carry row.
- R6: Sign handling works as follows. Bit W-1 of every operand is inverted. The constant (-6*2^(W-1)) mod 2^(W+3) is placed in bits W and above of the row built from `op0_i`. Operands of mixed sign therefore sum correctly.
- R7: With both register stages enabled (the default), operands present at rising edge k are captured at that edge. Their sum appears on `sum_o` just after edge k+1. Between those edges, `sum_o` still shows the sum of the operands captured at edge k-1.
- R8: `rst_n` is an asynchronous active-low reset. While it is low, `sum_o` is 0 at once. After release, `sum_o` stays 0 until the first operands captured after release reach the output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional register stages |
| rst_n | input | 1 | Asynchronous active-low reset of both register stages |
| op0_i | input | W | Signed operand 0 (its row also carries the sign bias) |
| op1_i | input | W | Signed operand 1 |
| op2_i | input | W | Signed operand 2 |
| op3_i | input | W | Signed operand 3 |
| op4_i | input | W | Signed operand 4 |
| op5_i | input | W | Signed operand 5 |
| sum_o | output | W+3 | Signed sum of the six operands |

## Verification
Every result is due one clock edge after the edge that captures its operands. That is two rising edges after the operands are driven. A reset forces `sum_o` to zero immediately, without waiting for an edge. The bench keeps a queue of expected sums that is pushed and popped on each rising edge. It compares `sum_o` at the following falling edge, so each check lands exactly where the output register has updated. A dedicated pair of checks confirms that the old sum is still shown after the first edge and the new one appears after the second. The per-level row totals and the final adder are checked every clock against an independent signed sum of the captured operands.

// File: rtl/csa6_pkg.sv
package csa6_pkg;

  // Number of operands; the reduction tree below is laid out for exactly this many.
  localparam int unsigned NUM_OPS = 6;

  // Extra result bits needed so that NUM_OPS signed values can never overflow.
  localparam int unsigned GUARD = $clog2(NUM_OPS);

  // Sum of the negative sign weights removed by inverting each operand MSB.
  // Adding this value back (modulo the result width) restores full sign extension.
  function automatic int sign_bias(input int unsigned w);
    return -(int'(NUM_OPS) * (1 << (w - 1)));
  endfunction

endpackage

// File: rtl/csa6_fa.sv
module csa6_fa (
  input  logic a_i,
  input  logic b_i,
  input  logic c_i,
  output logic s_o,
  output logic co_o
);

  assign s_o  = a_i ^ b_i ^ c_i;
  assign co_o = (a_i & b_i) | (a_i & c_i) | (b_i & c_i);

endmodule

// File: rtl/csa6_row.sv
// One 3:2 carry-save level: three rows in, a sum row and a left-shifted carry row out.
module csa6_row #(
  parameter int unsigned WIDTH = 9
) (
  input  logic [WIDTH-1:0] x_i,
  input  logic [WIDTH-1:0] y_i,
  input  logic [WIDTH-1:0] z_i,
  output logic [WIDTH-1:0] sum_o,
  output logic [WIDTH-1:0] carry_o
);

  logic [WIDTH-1:0] co_bits;

  assign carry_o[0] = 1'b0;

  for (genvar i = 0; i < WIDTH; i++) begin : g_col
    if (i < WIDTH - 1) begin : g_fa
      csa6_fa u_fa (
        .a_i  (x_i[i]),
        .b_i  (y_i[i]),
        .c_i  (z_i[i]),
        .s_o  (sum_o[i]),
        .co_o (co_bits[i])
      );
      assign carry_o[i+1] = co_bits[i];
    end else begin : g_top
      // The top column's carry leaves the result width, so only its parity is kept.
      assign sum_o[i]   = x_i[i] ^ y_i[i] ^ z_i[i];
      assign co_bits[i] = 1'b0;
    end
  end

endmodule

// File: rtl/csa6_cpa.sv
// Ripple carry-propagate adder built from the same full-adder cell, modulo 2^WIDTH.
module csa6_cpa #(
  parameter int unsigned WIDTH = 9
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] sum_o
);

  logic [WIDTH:0] carry;

  assign carry[0] = 1'b0;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    if (i < WIDTH - 1) begin : g_fa
      csa6_fa u_fa (
        .a_i  (a_i[i]),
        .b_i  (b_i[i]),
        .c_i  (carry[i]),
        .s_o  (sum_o[i]),
        .co_o (carry[i+1])
      );
    end else begin : g_top
      assign sum_o[i]   = a_i[i] ^ b_i[i] ^ carry[i];
      assign carry[i+1] = 1'b0;
    end
  end

endmodule

// File: rtl/csa6_adder.sv
module csa6_adder
  import csa6_pkg::*;
#(
  parameter int unsigned W       = 6,
  parameter bit          REG_IN  = 1'b1,
  parameter bit          REG_OUT = 1'b1,
  localparam int unsigned RW     = W + GUARD
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [W-1:0]  op0_i,
  input  logic [W-1:0]  op1_i,
  input  logic [W-1:0]  op2_i,
  input  logic [W-1:0]  op3_i,
  input  logic [W-1:0]  op4_i,
  input  logic [W-1:0]  op5_i,
  output logic [RW-1:0] sum_o
);

  localparam int unsigned FLAT = NUM_OPS * W;
  localparam int unsigned HI   = RW - W;

  // Bias word; its low W bits are zero because NUM_OPS is even.
  localparam logic [RW-1:0] BIAS    = RW'(sign_bias(W));
  localparam logic [HI-1:0] BIAS_HI = BIAS[RW-1:W];

  // ---------------------------------------------------------------- input stage
  logic [FLAT-1:0] op_in_flat;
  logic [FLAT-1:0] op_flat;

  assign op_in_flat = {op5_i, op4_i, op3_i, op2_i, op1_i, op0_i};

  if (REG_IN) begin : g_in_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) op_flat <= '0;
      else        op_flat <= op_in_flat;
    end
  end else begin : g_in_wire
    assign op_flat = op_in_flat;
  end

  // ----------------------------------------------------------- partial rows
  logic [RW-1:0] row [NUM_OPS];

  for (genvar i = 0; i < NUM_OPS; i++) begin : g_row
    localparam logic [HI-1:0] UPPER = (i == 0) ? BIAS_HI : '0;
    assign row[i] = {UPPER, ~op_flat[i*W + W-1], op_flat[i*W +: W-1]};
  end

  // --------------------------------------------------- level 1: six to four
  logic [RW-1:0] s_a, c_a, s_b, c_b;

  csa6_row #(.WIDTH(RW)) u_l1a (
    .x_i     (row[0]),
    .y_i     (row[1]),
    .z_i     (row[2]),
    .sum_o   (s_a),
    .carry_o (c_a)
  );

  csa6_row #(.WIDTH(RW)) u_l1b (
    .x_i     (row[3]),
    .y_i     (row[4]),
    .z_i     (row[5]),
    .sum_o   (s_b),
    .carry_o (c_b)
  );

  // --------------------------------------------------- level 2: four to three
  logic [RW-1:0] s_c, c_c;

  csa6_row #(.WIDTH(RW)) u_l2 (
    .x_i     (s_a),
    .y_i     (c_a),
    .z_i     (s_b),
    .sum_o   (s_c),
    .carry_o (c_c)
  );

  // ---------------------------------------------------- level 3: three to two
  logic [RW-1:0] s_d, c_d;

  csa6_row #(.WIDTH(RW)) u_l3 (
    .x_i     (s_c),
    .y_i     (c_c),
    .z_i     (c_b),
    .sum_o   (s_d),
    .carry_o (c_d)
  );

  // ------------------------------------------------ final carry-propagate add
  logic [RW-1:0] cpa_sum;

  csa6_cpa #(.WIDTH(RW)) u_cpa (
    .a_i   (s_d),
    .b_i   (c_d),
    .sum_o (cpa_sum)
  );

  // --------------------------------------------------------------- output stage
  if (REG_OUT) begin : g_out_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sum_o <= '0;
      else        sum_o <= cpa_sum;
    end
  end else begin : g_out_wire
    assign sum_o = cpa_sum;
  end

endmodule

// File: rtl/csa6_adder_chk.sv
module csa6_adder_chk
  import csa6_pkg::*;
#(
  parameter int unsigned W       = 6,
  parameter bit          REG_OUT = 1'b1,
  localparam int unsigned RW     = W + GUARD
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [NUM_OPS*W-1:0]  op_flat,
  input logic [RW-1:0]         s_a,
  input logic [RW-1:0]         c_a,
  input logic [RW-1:0]         s_b,
  input logic [RW-1:0]         c_b,
  input logic [RW-1:0]         s_c,
  input logic [RW-1:0]         c_c,
  input logic [RW-1:0]         s_d,
  input logic [RW-1:0]         c_d,
  input logic [RW-1:0]         cpa_sum,
  input logic [RW-1:0]         sum_o
);

  // Plain sign-extended sum, written independently of the bias trick.
  function automatic logic [RW-1:0] ext_sum(input logic [NUM_OPS*W-1:0] v);
    logic [RW-1:0] acc;
    acc = '0;
    for (int i = 0; i < NUM_OPS; i++) begin
      acc = acc + {{(RW-W){v[i*W + W-1]}}, v[i*W +: W]};
    end
    return acc;
  endfunction

  logic [RW-1:0] want;
  logic [RW-1:0] lvl1_total;
  logic [RW-1:0] lvl2_total;
  logic [RW-1:0] lvl3_total;

  assign want       = ext_sum(op_flat);
  assign lvl1_total = s_a + c_a + s_b + c_b;
  assign lvl2_total = s_c + c_c + c_b;
  assign lvl3_total = s_d + c_d;

  a_r1_signed_sum: assert property (@(posedge clk) disable iff (!rst_n)
    cpa_sum == want);

  a_r3_level1_conserve: assert property (@(posedge clk) disable iff (!rst_n)
    lvl1_total == want);

  a_r4_level2_conserve: assert property (@(posedge clk) disable iff (!rst_n)
    lvl2_total == lvl1_total);

  a_r4_level3_conserve: assert property (@(posedge clk) disable iff (!rst_n)
    lvl3_total == lvl2_total);

  a_r5_cpa_exact: assert property (@(posedge clk) disable iff (!rst_n)
    cpa_sum == lvl3_total);

  if (REG_OUT) begin : g_out_chk
    a_r7_output_stage: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> sum_o == $past(cpa_sum));
  end

endmodule

bind csa6_adder csa6_adder_chk #(.W(W), .REG_OUT(REG_OUT)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .op_flat (op_flat),
  .s_a     (s_a),
  .c_a     (c_a),
  .s_b     (s_b),
  .c_b     (c_b),
  .s_c     (s_c),
  .c_c     (c_c),
  .s_d     (s_d),
  .c_d     (c_d),
  .cpa_sum (cpa_sum),
  .sum_o   (sum_o)
);

// File: tb/tb_csa6_adder.sv
module tb_csa6_adder;

  localparam int W  = 6;
  localparam int RW = W + 3;
  localparam int N  = 6;
  localparam int VMIN = -(1 << (W - 1));
  localparam int VMAX = (1 << (W - 1)) - 1;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [W-1:0]  op [N];
  logic [RW-1:0] sum_o;

  int checks = 0;
  int errors = 0;
  logic [RW-1:0] exp_q [$];
  logic [RW-1:0] cur_exp;

  always #5 clk = ~clk;

  csa6_adder dut (
    .clk   (clk),
    .rst_n (rst_n),
    .op0_i (op[0]),
    .op1_i (op[1]),
    .op2_i (op[2]),
    .op3_i (op[3]),
    .op4_i (op[4]),
    .op5_i (op[5]),
    .sum_o (sum_o)
  );

  // Behavioural reference: integer sum of the operands read as signed values.
  function automatic logic [RW-1:0] ref_sum();
    int s;
    s = 0;
    for (int i = 0; i < N; i++) s += int'($signed(op[i]));
    return RW'(s);
  endfunction

  task automatic check(input string req, input logic [RW-1:0] e);
    checks++;
    if (sum_o !== e) begin
      errors++;
      $display("FAIL %s: sum_o=%0d expected %0d", req, $signed(sum_o), $signed(e));
    end
  endtask

  task automatic set_all(input int v);
    for (int i = 0; i < N; i++) op[i] = W'(v);
  endtask

  task automatic set_ops(input int v0, input int v1, input int v2,
                         input int v3, input int v4, input int v5);
    op[0] = W'(v0); op[1] = W'(v1); op[2] = W'(v2);
    op[3] = W'(v3); op[4] = W'(v4); op[5] = W'(v5);
  endtask

  // One clock: the model advances at the rising edge, the output is compared at the falling edge.
  task automatic tick(input string req);
    @(posedge clk);
    if (rst_n) begin
      exp_q.push_back(ref_sum());
      cur_exp = exp_q.pop_front();
    end
    @(negedge clk);
    check(req, cur_exp);
  endtask

  task automatic model_reset();
    exp_q.delete();
    exp_q.push_back('0);
    cur_exp = '0;
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: run did not complete, actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    set_all(0);
    model_reset();
    #1;
    check("R8 reset at time zero", '0);
    repeat (2) @(negedge clk);
    check("R8 held in reset", '0);
    rst_n = 1'b1;

    // R8: output stays zero until fresh operands reach it.
    set_all(0);
    tick("R8 after release");

    // R7: the sum of +1 x6 must not show after one edge, and must show after two.
    set_all(1);
    tick("R7 old value after first edge");
    tick("R7 new value after second edge");
    if (sum_o !== RW'(6)) begin
      errors++;
      $display("FAIL R7: sum_o=%0d expected 6", $signed(sum_o));
    end
    checks++;

    // R2: extreme corners, held so both stages fill.
    set_all(VMIN);
    tick("R2 all-minimum");
    tick("R2 all-minimum");
    checks++;
    if (sum_o !== 9'h140) begin
      errors++;
      $display("FAIL R2: sum_o=%0d expected -192", $signed(sum_o));
    end
    set_all(VMAX);
    tick("R2 all-maximum");
    tick("R2 all-maximum");
    checks++;
    if (sum_o !== RW'(186)) begin
      errors++;
      $display("FAIL R2: sum_o=%0d expected 186", $signed(sum_o));
    end

    // R6: mixed signs and single negative operand in each position.
    set_ops(VMIN, VMAX, -1, 0, 1, VMIN);     tick("R6 mixed");
    set_ops(-1, -1, -1, -1, -1, -1);         tick("R6 all minus one");
    set_ops(VMAX, VMAX, VMAX, VMIN, VMIN, VMIN); tick("R6 balanced");
    for (int p = 0; p < N; p++) begin
      set_all(0);
      op[p] = W'(VMIN);
      tick("R6 single negative");
    end
    set_ops(0, VMAX, VMAX, VMAX, VMAX, VMAX); tick("R6 row0 zero");
    set_ops(VMIN, 0, 0, 0, 0, 0);             tick("R6 row0 only");
    tick("R6 drain");

    // R1 R3 R4 R5: random operands every cycle.
    for (int k = 0; k < 400; k++) begin
      for (int i = 0; i < N; i++) op[i] = W'($urandom_range(0, (1 << W) - 1));
      tick("R1 R3 R4 R5 random");
    end

    // R8: asynchronous reset in the middle of a busy pipeline.
    set_all(VMAX);
    tick("R8 before reset");
    rst_n = 1'b0;
    #1;
    check("R8 async clear", '0);
    model_reset();
    tick("R8 during reset");
    rst_n = 1'b1;
    tick("R8 first edge after release");
    tick("R8 result after release");

    set_all(0);
    tick("R1 drain");
    tick("R1 drain");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule